// File: doc/BRIEF.md
# MDIO Management Master with Command Word

This block runs Clause 22 management transactions toward PHY devices over the MDC clock and the bidirectional MDIO line. Software controls it through two 32-bit registers on a simple write strobe bus. The command word carries every field of a transaction in one write: an opcode, a PHY address, a register address, 16 data bits, the start bit and a busy flag. The timing word sets the MDC half period, the point in each MDC period at which the line is sampled, the point at which the next output bit is launched, and two bits that must both be set before the pad driver is enabled.

Software starts a transaction by writing a command with busy set. The block sends a 32-bit preamble of ones, the start pair, the opcode, both addresses, the turnaround pair and the data, most significant bit first, one bit per MDC period. It then clears busy. On a read it lets go of the line for the turnaround and the data bits and shifts in the PHY's reply. The reply appears in the data field of the command word when the frame ends. Each completed transaction leaves the word locked. Software collects the result and then writes an all-zero word, which releases the lock. The same zero write cancels a transaction that is still running.

Top module: `mdio_gw_master`

## Requirements
- R1: After reset the command word reads 0, the timing word reads 0x030D0609 (half period field 9, sample point 6, launch point 13, both drive-enable bits set), MDC is low and the output enable is low.
- R2: A nonzero write to the command word (reg_sel=0) with bit 31 set, made while the word is neither busy nor locked, stores bits 28:0 and starts a frame. Bit 31 reads 1 until the frame ends, and each such command produces exactly one frame.
- R3: The frame is 64 MDC periods long: 32 ones, then 0 and the start bit (bit 28), the opcode (bits 27:26, 01 write, 10 read), the PHY address (bits 25:21), the register address (bits 20:16), the turnaround and 16 data bits (bits 15:0). All fields go out MSB first. On a write the turnaround is 1 then 0 and the output enable is high for all 64 bits.
- R4: On a read the output enable is low from bit 46 through bit 63. mdio_i is sampled in data bits 48 to 63, and the 16 sampled bits replace bits 15:0 of the command word when the frame ends.
- R5: MDC idles low. During a frame each MDC period is 2×(H+1) clock cycles, high for the first H+1 of them, where H is timing word bits 7:0.
- R6: Each period counts clock cycles from 0 at the rising edge of MDC. The next bit appears on mdio_o O+1 cycles after the rise, where O is timing bits 23:16. mdio_i is sampled in the cycle where the count equals I, where I is timing bits 15:8.
- R7: When a frame ends, busy (bit 31) clears, lock (bit 30) sets, MDC is low and the output enable is low.
- R8: While locked, nonzero writes to the command word are ignored: no frame runs and the word keeps its contents. An all-zero write clears the whole word, including the lock.
- R9: While busy, nonzero command writes and all writes to the timing word are ignored, and the data field keeps its value until the frame ends.
- R10: An all-zero command write during a frame aborts it. In the next cycle busy and lock are 0 and MDC and the output enable are low, and a new command is then accepted.
- R11: mdio_oe is high only if timing bit 24 (mode) and bit 25 (full drive) are both 1. The frame still runs when either bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 command word, 1 timing word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable for the pad |
| mdio_i | input | 1 | MDIO value from the pad |

## Verification
The bench's PHY model gives the correct reply bit only in the single cycle at the programmed sample point and gives the inverted bit in every other cycle. A design that samples one cycle early or late therefore returns the complement of the expected data. The lock and busy gates are tested with commands that must start nothing, so a design that lets them through sends a frame the scoreboard never expected. Two timing settings check the MDC period and launch point, catching an off-by-one in the half-period count or a launch made at the wrong edge. An abort in the middle of a frame followed by a fresh command catches a design that leaves the lock or the clock running.

// File: rtl/mdio_gw_pkg.sv
package mdio_gw_pkg;

  localparam int CFG_W = 8;

  localparam logic [5:0] IDX_TA   = 6'd46;
  localparam logic [5:0] IDX_DATA = 6'd48;
  localparam logic [5:0] IDX_LAST = 6'd63;

  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;

  typedef struct packed {
    logic        busy;
    logic        lock;
    logic        rsv;
    logic        st;
    logic [1:0]  op;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] data;
  } gw_word_t;

  typedef struct packed {
    logic [5:0]       rsv;
    logic             full;
    logic             mode;
    logic [CFG_W-1:0] out_pt;
    logic [CFG_W-1:0] in_pt;
    logic [CFG_W-1:0] half;
  } cfg_word_t;

  // Second half of the frame (bits 32..63) built from a command word.
  function automatic logic [31:0] frame_tail(input gw_word_t w);
    logic [1:0] ta;
    ta = (w.op == OP_RD) ? 2'b11 : 2'b10;
    return {1'b0, w.st, w.op, w.phy, w.regad, ta, w.data};
  endfunction

  // Wire value of frame bit n: preamble ones, then the tail MSB first.
  function automatic logic frame_bit(input logic [31:0] tail, input logic [5:0] n);
    return n[5] ? tail[~n[4:0]] : 1'b1;
  endfunction

endpackage

// File: rtl/mdio_gw_regs.sv
module mdio_gw_regs
  import mdio_gw_pkg::*;
#(
  parameter logic [CFG_W-1:0] DEF_HALF = 8'd9,
  parameter logic [CFG_W-1:0] DEF_IN   = 8'd6,
  parameter logic [CFG_W-1:0] DEF_OUT  = 8'd13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic        sel,
  input  logic [31:0] wdata,
  input  logic        done_i,
  input  logic [15:0] cap_i,
  output gw_word_t    gw,
  output cfg_word_t   cfg,
  output logic        start,
  output logic        abort
);

  logic zero_wr, cmd_wr, cmd_open;

  assign zero_wr  = wr && !sel && (wdata == 32'd0);
  assign cmd_wr   = wr && !sel && (wdata != 32'd0);
  assign cmd_open = !gw.busy && !gw.lock;
  assign start    = cmd_wr && cmd_open && wdata[31];
  assign abort    = zero_wr && gw.busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gw  <= '0;
      cfg <= '{rsv: '0, full: 1'b1, mode: 1'b1,
               out_pt: DEF_OUT, in_pt: DEF_IN, half: DEF_HALF};
    end else begin
      if (zero_wr) begin
        gw <= '0;
      end else if (cmd_wr && cmd_open) begin
        gw      <= gw_word_t'(wdata);
        gw.lock <= 1'b0;
        gw.rsv  <= 1'b0;
      end else if (done_i) begin
        gw.busy <= 1'b0;
        gw.lock <= 1'b1;
        if (gw.op == OP_RD) gw.data <= cap_i;
      end
      if (wr && sel && !gw.busy) begin
        cfg     <= cfg_word_t'(wdata);
        cfg.rsv <= '0;
      end
    end
  end

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (gw.busy && !done_i && !zero_wr) |=> gw.busy); // R2
  AST_LOCK_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !zero_wr) |=> (gw.lock && !gw.busy)); // R7
  AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (gw.lock && cmd_wr) |=> !gw.busy); // R8
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    gw.busy |=> $stable(cfg)); // R9

endmodule

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [PW-1:0] half,
  input  logic [PW-1:0] in_pt,
  input  logic [PW-1:0] out_pt,
  output logic          mdc,
  output logic          out_stb,
  output logic          in_stb,
  output logic          period_end
);

  localparam int CW = PW + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last       = {half, 1'b1};
  assign period_end = run && (cnt == last);
  assign out_stb    = run && (cnt == {1'b0, out_pt});
  assign in_stb     = run && (cnt == {1'b0, in_pt});
  assign mdc        = run && (cnt <= {1'b0, half});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (!run || period_end) cnt <= '0;
    else                         cnt <= cnt + 1'b1;
  end

  AST_PERIOD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= last)); // R5

endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_gw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] tail_in,
  input  logic        rd_in,
  input  logic        abort,
  input  logic        out_stb,
  input  logic        in_stb,
  input  logic        period_end,
  input  logic        mdio_i,
  output logic        active,
  output logic        drv_o,
  output logic        drv_en,
  output logic        done,
  output logic [15:0] cap
);

  logic [5:0]  bitn;
  logic [5:0]  nxt;
  logic [31:0] tail;
  logic        rd;

  assign nxt = bitn + 6'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      drv_o  <= 1'b0;
      drv_en <= 1'b0;
      done   <= 1'b0;
      cap    <= '0;
      bitn   <= '0;
      tail   <= '0;
      rd     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        active <= 1'b0;
        drv_en <= 1'b0;
        drv_o  <= 1'b0;
      end else if (start) begin
        active <= 1'b1;
        bitn   <= '0;
        tail   <= tail_in;
        rd     <= rd_in;
        drv_o  <= 1'b1;
        drv_en <= 1'b1;
      end else if (active) begin
        if (out_stb && bitn != IDX_LAST) begin
          drv_o  <= frame_bit(tail, nxt);
          drv_en <= !(rd && nxt >= IDX_TA);
        end
        if (in_stb && rd && bitn >= IDX_DATA) cap <= {cap[14:0], mdio_i};
        if (period_end) begin
          if (bitn == IDX_LAST) begin
            active <= 1'b0;
            done   <= 1'b1;
            drv_en <= 1'b0;
            drv_o  <= 1'b0;
          end else begin
            bitn <= nxt;
          end
        end
      end
    end
  end

  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && rd && bitn >= IDX_TA) |-> !drv_en); // R4
  AST_DONE_FROM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!active && !drv_en && $past(active))); // R7

endmodule

// File: rtl/mdio_gw_master.sv
module mdio_gw_master
  import mdio_gw_pkg::*;
#(
  parameter logic [CFG_W-1:0] DEF_HALF = 8'd9,
  parameter logic [CFG_W-1:0] DEF_IN   = 8'd6,
  parameter logic [CFG_W-1:0] DEF_OUT  = 8'd13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  gw_word_t  gw;
  cfg_word_t cfg;
  gw_word_t  new_cmd;
  logic      start, abort, done, active;
  logic      out_stb, in_stb, period_end;
  logic      drv_o, drv_en;
  logic [15:0] cap;

  assign new_cmd = gw_word_t'(reg_wdata);

  mdio_gw_regs #(
    .DEF_HALF(DEF_HALF), .DEF_IN(DEF_IN), .DEF_OUT(DEF_OUT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .done_i(done), .cap_i(cap), .gw(gw), .cfg(cfg), .start(start), .abort(abort)
  );

  mdio_mdc_gen #(.PW(CFG_W)) u_mdc (
    .clk(clk), .rst_n(rst_n), .run(active), .half(cfg.half),
    .in_pt(cfg.in_pt), .out_pt(cfg.out_pt), .mdc(mdc),
    .out_stb(out_stb), .in_stb(in_stb), .period_end(period_end)
  );

  mdio_frame_eng u_frame (
    .clk(clk), .rst_n(rst_n), .start(start), .tail_in(frame_tail(new_cmd)),
    .rd_in(new_cmd.op == OP_RD), .abort(abort), .out_stb(out_stb),
    .in_stb(in_stb), .period_end(period_end), .mdio_i(mdio_i),
    .active(active), .drv_o(drv_o), .drv_en(drv_en), .done(done), .cap(cap)
  );

  assign mdio_o    = drv_o;
  assign mdio_oe   = drv_en && cfg.mode && cfg.full;
  assign reg_rdata = reg_sel ? 32'(cfg) : 32'(gw);

  AST_MDC_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !gw.busy |-> !mdc); // R7
  AST_OE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> gw.busy); // R11

endmodule

// File: tb/test_mdio_gw_master.sv
`timescale 1ns/1ps
module test_mdio_gw_master;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  always #4 clk = ~clk;

  mdio_gw_master i_mdio_gw_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct {
    logic [63:0] bits;
    logic [63:0] oe;
    string       tag;
  } exp_t;
  exp_t exp_q[$];
  exp_t e;

  int c_half = 9, c_in = 6, c_out = 13;
  logic [15:0] phy_resp = '0;

  function automatic exp_t mk(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra,
                              input logic [15:0] d, input bit drv, input string tag);
    exp_t x;
    logic [31:0] t;
    t = {2'b01, op, phy, ra, (op == 2'b10) ? 2'b00 : 2'b10, d};
    for (int k = 0; k < 64; k++) begin
      x.bits[k] = (k < 32) ? 1'b1 : t[63-k];
      x.oe[k]   = drv && !(op == 2'b10 && k >= 46);
    end
    x.tag = tag;
    return x;
  endfunction

  // Monitor and PHY model
  logic mdc_q = 1'b0;
  int r = 0, delta = 1000, idx = 0, out_meas = -1;
  bit per_bad = 1'b0, hi_bad = 1'b0;
  logic [63:0] gb = '0, go = '0;

  always @(negedge clk) begin
    if (mdc && !mdc_q) begin
      if (delta > 4 * (c_half + 1)) r = 0;
      if (r == 0) begin
        per_bad = 1'b0; hi_bad = 1'b0; out_meas = -1;
      end else if (delta != 2 * c_half + 1) begin
        per_bad = 1'b1;
      end
      gb[r] = mdio_o;
      go[r] = mdio_oe;
      idx = r;
      delta = 0;
      if (r == 63) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected frame", gb, 64'd0);
        end else begin
          e = exp_q.pop_front();
          chk(((gb ^ e.bits) & e.oe) == 64'd0, {e.tag, " wire bits"}, gb & e.oe, e.bits & e.oe);
          chk(go == e.oe, {e.tag, " output enable per bit"}, go, e.oe);
          chk(!per_bad && !hi_bad, "R5 mdc period and high time", {62'd0, per_bad, hi_bad}, 64'd0);
          chk(out_meas == c_out + 1, "R6 launch point", 64'(out_meas), 64'(c_out + 1));
        end
        r = 0;
      end else begin
        r++;
      end
    end else begin
      if (delta < 100000) delta++;
      if (!mdc && mdc_q && delta != c_half + 1) hi_bad = 1'b1;
    end
    if (idx == 31 && out_meas < 0 && mdio_o == 1'b0) out_meas = delta;
    // R6: the reply bit is correct only in the sample cycle
    if (idx >= 48) mdio_i = (delta == c_in) ? phy_resp[63-idx] : ~phy_resp[63-idx];
    else           mdio_i = 1'b1;
    mdc_q = mdc;
  end

  task automatic wr(input bit s, input logic [31:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 1'b0;
  endtask

  task automatic rd(input bit s, output logic [31:0] v);
    reg_sel = s;
    #1;
    v = reg_rdata;
    reg_sel = 1'b0;
  endtask

  task automatic cmd(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra,
                     input logic [15:0] d, input bit drv, input string tag);
    exp_q.push_back(mk(op, phy, ra, d, drv, tag));
    wr(1'b0, {1'b1, 1'b0, 1'b0, 1'b1, op, phy, ra, d});
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    do begin
      @(negedge clk);
      rd(1'b0, v);
    end while (v[31]);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R2 run did not finish actual=%h expected=%h", 64'd1, 64'd0);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    bit mdc_seen;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(1'b0, v); chk(v == 32'd0, "R1 command word", 64'(v), 64'd0);
    rd(1'b1, v); chk(v == 32'h030D0609, "R1 timing word", 64'(v), 64'h030D0609);
    chk(!mdc && !mdio_oe, "R1 pins idle", {62'd0, mdc, mdio_oe}, 64'd0);

    // R2 R3 write frame, R9 writes while busy
    cmd(2'b01, 5'h11, 5'h04, 16'hA5C3, 1'b1, "R3 write");
    rd(1'b0, v);
    chk(v == {4'b1001, 2'b01, 5'h11, 5'h04, 16'hA5C3}, "R2 busy readback", 64'(v),
        64'({4'b1001, 2'b01, 5'h11, 5'h04, 16'hA5C3}));
    repeat (200) @(negedge clk);
    wr(1'b0, 32'h9BFF_FFFF);
    wr(1'b1, 32'h0300_0101);
    rd(1'b0, v);
    chk(v == {4'b1001, 2'b01, 5'h11, 5'h04, 16'hA5C3}, "R9 command kept while busy", 64'(v),
        64'({4'b1001, 2'b01, 5'h11, 5'h04, 16'hA5C3}));
    rd(1'b1, v); chk(v == 32'h030D0609, "R9 timing kept while busy", 64'(v), 64'h030D0609);
    wait_idle();
    rd(1'b0, v);
    chk(v == {4'b0101, 2'b01, 5'h11, 5'h04, 16'hA5C3}, "R7 lock after write", 64'(v),
        64'({4'b0101, 2'b01, 5'h11, 5'h04, 16'hA5C3}));
    chk(!mdc && !mdio_oe, "R7 pins released", {62'd0, mdc, mdio_oe}, 64'd0);

    // R8 locked: commands ignored
    wr(1'b0, {4'b1001, 2'b10, 5'h02, 5'h03, 16'h0000});
    mdc_seen = 1'b0;
    repeat (100) begin @(negedge clk); if (mdc) mdc_seen = 1'b1; end
    chk(!mdc_seen, "R8 no frame while locked", {63'd0, mdc_seen}, 64'd0);
    rd(1'b0, v);
    chk(v == {4'b0101, 2'b01, 5'h11, 5'h04, 16'hA5C3}, "R8 word unchanged while locked", 64'(v),
        64'({4'b0101, 2'b01, 5'h11, 5'h04, 16'hA5C3}));
    wr(1'b0, 32'd0);
    rd(1'b0, v); chk(v == 32'd0, "R8 zero write releases", 64'(v), 64'd0);

    // R4 read frame
    phy_resp = 16'h3C5A;
    cmd(2'b10, 5'h03, 5'h01, 16'h0000, 1'b1, "R4 read");
    wait_idle();
    rd(1'b0, v);
    chk(v == {4'b0101, 2'b10, 5'h03, 5'h01, 16'h3C5A}, "R4 read data", 64'(v),
        64'({4'b0101, 2'b10, 5'h03, 5'h01, 16'h3C5A}));
    wr(1'b0, 32'd0);

    // R4 R9 second read, command write while busy
    phy_resp = 16'hF00D;
    cmd(2'b10, 5'h1F, 5'h1F, 16'h1234, 1'b1, "R4 read max address");
    repeat (300) @(negedge clk);
    rd(1'b0, v);
    chk(v[15:0] == 16'h1234, "R9 data field held while busy", 64'(v[15:0]), 64'h1234);
    wr(1'b0, 32'hFFFF_FFFF);
    wait_idle();
    rd(1'b0, v);
    chk(v == {4'b0101, 2'b10, 5'h1F, 5'h1F, 16'hF00D}, "R9 R4 result after ignored write", 64'(v),
        64'({4'b0101, 2'b10, 5'h1F, 5'h1F, 16'hF00D}));
    wr(1'b0, 32'd0);

    // R5 R6 new timing
    c_half = 4; c_in = 2; c_out = 7;
    wr(1'b1, 32'h0307_0204);
    rd(1'b1, v); chk(v == 32'h0307_0204, "R5 timing write", 64'(v), 64'h03070204);
    phy_resp = 16'h8001;
    cmd(2'b10, 5'h0A, 5'h15, 16'h0000, 1'b1, "R5 R6 read short period");
    wait_idle();
    rd(1'b0, v);
    chk(v[15:0] == 16'h8001, "R6 sample point data", 64'(v[15:0]), 64'h8001);
    wr(1'b0, 32'd0);
    cmd(2'b01, 5'h15, 5'h0A, 16'h5A5A, 1'b1, "R5 write short period");
    wait_idle();
    wr(1'b0, 32'd0);

    // R11 driver enable gating
    wr(1'b1, 32'h0207_0204);
    cmd(2'b01, 5'h01, 5'h02, 16'hFFFF, 1'b0, "R11 mode off");
    wait_idle();
    wr(1'b0, 32'd0);
    wr(1'b1, 32'h0107_0204);
    cmd(2'b01, 5'h01, 5'h02, 16'h0001, 1'b0, "R11 full drive off");
    wait_idle();
    wr(1'b0, 32'd0);

    // R10 abort
    c_half = 9; c_in = 6; c_out = 13;
    wr(1'b1, 32'h030D0609);
    wr(1'b0, {4'b1001, 2'b01, 5'h07, 5'h07, 16'h7777});
    repeat (300) @(negedge clk);
    wr(1'b0, 32'd0);
    rd(1'b0, v);
    chk(v == 32'd0 && !mdc && !mdio_oe, "R10 abort clears", {mdc, mdio_oe, 30'd0, v}, 64'd0);
    mdc_seen = 1'b0;
    repeat (100) begin @(negedge clk); if (mdc) mdc_seen = 1'b1; end
    chk(!mdc_seen, "R10 clock stopped after abort", {63'd0, mdc_seen}, 64'd0);
    cmd(2'b01, 5'h0C, 5'h13, 16'hC0DE, 1'b1, "R10 command after abort");
    wait_idle();
    wr(1'b0, 32'd0);

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R2 one frame per command", 64'(exp_q.size()), 64'd0);
    summary();
    $finish;
  end

endmodule